// File: doc/BRIEF.md
# Character Display Start-Up Sequencer

After reset this block runs the fixed, timed bring-up that a character display needs before it accepts text. It first waits out the display's power-on settling time. It then sends three wake-up nibbles of value 3, with shrinking pauses between them, and one nibble of value 2 that moves the display to its 4-bit interface. Last, it sends four byte-wide configuration commands and waits for the clear command to finish.

The block does not drive the display pins. Each transfer goes as a request to a separate write engine, which splits bytes into nibbles and produces the enable pulse. A request is held until that engine signals it can take it. Once the final wait has run out, `done_o` rises. From then on the display belongs to whatever writes text.

All delays are parameters given in clock cycles. Their defaults are the minimum times at a 50 MHz clock. An asynchronous reset, at any point, restarts the whole sequence from the power-on wait.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `req_o` and `done_o` are low. `req_o` first goes high after exactly PWR_CYC rising clock edges following reset release.
- R2: The first four requests have `nibble_o`=1. They carry, in order, the values 0x3, 0x3, 0x3 and 0x2 in `data_o[3:0]`, with `data_o[7:4]`=0.
- R3: After each of the four nibble transfers is accepted, `req_o` stays low for exactly WAIT1_CYC, WAIT2_CYC, WAIT3_CYC and WAIT4_CYC cycles in turn. The next request then appears.
- R4: Four byte requests follow with `nibble_o`=0, in this order: 0x28 (function set), 0x06 (entry mode, address auto-increment), 0x0C (display on, cursor and blink off) and 0x01 (clear). Each byte after the first is presented in the cycle right after the previous byte is accepted.
- R5: `rs_o` is 0 whenever a request is presented, because every transfer of the sequence is a command.
- R6: A request is accepted on a rising edge where `req_o` and `rdy_i` are both high. Until then `req_o`, `data_o` and `nibble_o` hold their values.
- R7: `done_o` rises exactly CLR_CYC cycles after the clear command is accepted. It then stays high and `req_o` stays low until reset.
- R8: A reset asserted partway through the sequence restarts it. The next request comes PWR_CYC edges after release and is again the first 0x3 nibble.
- R9: One full sequence accepts exactly eight transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rdy_i | input | 1 | Write engine can take a request |
| req_o | output | 1 | Request presented to the write engine |
| nibble_o | output | 1 | 1: send data_o[3:0] as one nibble; 0: send data_o as a byte |
| data_o | output | 8 | Nibble or command byte |
| rs_o | output | 1 | Register select for the transfer (command = 0) |
| done_o | output | 1 | Start-up complete, display ready for text |

## Verification
Every result of this block is due a fixed number of edges after an event:
- the first request, PWR_CYC edges after reset release;
- each nibble's successor, its post-wait count of edges after acceptance;
- each byte's successor, one edge after acceptance;
- `done_o`, CLR_CYC edges after the clear is accepted.

A behavioural model in the bench counts those same edges from the `rdy_i` it drives. It is compared against the outputs half a cycle after every edge, so an early or late change shows up in the exact cycle it happens. `rdy_i` is driven high all the time, pseudo-randomly, and in long low bursts, which moves acceptance edges around. This shows that every wait is measured from acceptance and not from when the request was presented.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;
  typedef enum logic [1:0] {
    S_PWR  = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2,
    S_DONE = 2'd3
  } seq_state_e;

  localparam int unsigned NUM_STEPS = 8;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lcd_init_timer.sv
module lcd_init_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lcd_init_steps.sv
module lcd_init_steps
  import lcd_init_pkg::*;
#(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned WAIT1_CYC = 205000,
  parameter int unsigned WAIT2_CYC = 5000,
  parameter int unsigned WAIT3_CYC = 2000,
  parameter int unsigned WAIT4_CYC = 2000,
  parameter int unsigned CLR_CYC   = 82000
) (
  input  logic [STEP_W-1:0] idx_i,
  output logic [7:0]        data_o,
  output logic              nibble_o,
  output logic [CNT_W-1:0]  wait_o,
  output logic              last_o
);
  always_comb begin
    data_o   = 8'h00;
    nibble_o = 1'b0;
    wait_o   = '0;
    unique case (idx_i)
      3'd0: begin data_o = 8'h03; nibble_o = 1'b1; wait_o = CNT_W'(WAIT1_CYC); end
      3'd1: begin data_o = 8'h03; nibble_o = 1'b1; wait_o = CNT_W'(WAIT2_CYC); end
      3'd2: begin data_o = 8'h03; nibble_o = 1'b1; wait_o = CNT_W'(WAIT3_CYC); end
      3'd3: begin data_o = 8'h02; nibble_o = 1'b1; wait_o = CNT_W'(WAIT4_CYC); end
      3'd4: data_o = 8'h28;
      3'd5: data_o = 8'h06;
      3'd6: data_o = 8'h0C;
      default: begin data_o = 8'h01; wait_o = CNT_W'(CLR_CYC); end
    endcase
  end

  assign last_o = (idx_i == STEP_W'(NUM_STEPS - 1));
endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int unsigned PWR_CYC   = 750000,
  parameter int unsigned WAIT1_CYC = 205000,
  parameter int unsigned WAIT2_CYC = 5000,
  parameter int unsigned WAIT3_CYC = 2000,
  parameter int unsigned WAIT4_CYC = 2000,
  parameter int unsigned CLR_CYC   = 82000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rdy_i,
  output logic       req_o,
  output logic       nibble_o,
  output logic [7:0] data_o,
  output logic       rs_o,
  output logic       done_o
);
  localparam int unsigned MAX_CYC = max_u(max_u(max_u(PWR_CYC, WAIT1_CYC), max_u(WAIT2_CYC, WAIT3_CYC)),
                                          max_u(WAIT4_CYC, CLR_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CNT_W-1:0]  cnt, step_wait, limit;
  logic              step_last, hit, accept, timing;

  lcd_init_steps #(
    .CNT_W(CNT_W), .WAIT1_CYC(WAIT1_CYC), .WAIT2_CYC(WAIT2_CYC),
    .WAIT3_CYC(WAIT3_CYC), .WAIT4_CYC(WAIT4_CYC), .CLR_CYC(CLR_CYC)
  ) u_steps (
    .idx_i   (step_q),
    .data_o  (data_o),
    .nibble_o(nibble_o),
    .wait_o  (step_wait),
    .last_o  (step_last)
  );

  // one shared counter: power-on wait and all post-transfer waits
  assign timing = (state_q == S_PWR) || (state_q == S_WAIT);
  assign limit  = (state_q == S_PWR) ? CNT_W'(PWR_CYC) : step_wait;
  assign hit    = timing && (cnt == limit - 1'b1);

  lcd_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!timing || hit),
    .cnt_o (cnt)
  );

  assign accept = (state_q == S_REQ) && rdy_i;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    unique case (state_q)
      S_PWR:  if (hit) state_d = S_REQ;
      S_REQ:  if (accept) begin
        if (step_wait != '0)  state_d = S_WAIT;
        else                  step_d  = step_q + 1'b1;
      end
      S_WAIT: if (hit) begin
        if (step_last) state_d = S_DONE;
        else begin
          state_d = S_REQ;
          step_d  = step_q + 1'b1;
        end
      end
      default: state_d = S_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_PWR;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign req_o  = (state_q == S_REQ);
  assign rs_o   = 1'b0;
  assign done_o = (state_q == S_DONE);
endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rdy_i,
  input logic       req_o,
  input logic       nibble_o,
  input logic [7:0] data_o,
  input logic       done_o
);
  a_r6_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !rdy_i |=> req_o && $stable(data_o) && $stable(nibble_o));

  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r7_no_req_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o);

  a_r2_nibble_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && nibble_o |-> data_o[7:4] == 4'h0);

  a_r3_gap_after_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && rdy_i && nibble_o |=> !req_o);

  a_r4_bytes_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && rdy_i && !nibble_o && data_o != 8'h01 |=> req_o && !nibble_o);

  a_r7_done_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !req_o && !$past(req_o));
endmodule

bind lcd_init_seq lcd_init_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rdy_i   (rdy_i),
  .req_o   (req_o),
  .nibble_o(nibble_o),
  .data_o  (data_o),
  .done_o  (done_o)
);

// File: tb/lcd_init_seq_tb.sv
module lcd_init_seq_tb;
  localparam int PWR = 40, W1 = 25, W2 = 12, W3 = 6, W4 = 5, CLR = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rdy_i = 1'b1;
  logic       req_o, nibble_o, rs_o, done_o;
  logic [7:0] data_o;

  lcd_init_seq #(
    .PWR_CYC(PWR), .WAIT1_CYC(W1), .WAIT2_CYC(W2),
    .WAIT3_CYC(W3), .WAIT4_CYC(W4), .CLR_CYC(CLR)
  ) u_dut (.*);

  always #5 clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0, cyc = 0, mode = 0, n_acc = 0;
  logic [7:0] lfsr = 8'hA5;
  string mid_tag = "R1";

  // behavioural reference: list of transfers and a gap counter
  int qd[$], qn[$], qw[$];
  int gap;
  bit e_req, e_done;
  string ctx;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qd = '{8'h03, 8'h03, 8'h03, 8'h02, 8'h28, 8'h06, 8'h0C, 8'h01};
      qn = '{1, 1, 1, 1, 0, 0, 0, 0};
      qw = '{W1, W2, W3, W4, 0, 0, 0, CLR};
      gap = PWR; e_req = 0; e_done = 0; ctx = mid_tag; n_acc = 0;
    end else begin
      if (req_o && rdy_i) n_acc++;
      if (e_req && rdy_i) begin
        ctx = (qn[0] != 0) ? "R3" : "R4";
        gap = qw[0];
        void'(qd.pop_front()); void'(qn.pop_front()); void'(qw.pop_front());
        if (gap == 0) begin
          e_done = (qd.size() == 0);
          e_req  = !e_done;
        end else e_req = 0;
        if (qd.size() == 0) ctx = "R7";
      end else if (!e_req && !e_done) begin
        gap--;
        if (gap == 0) begin
          if (qd.size() == 0) e_done = 1;
          else e_req = 1;
        end
      end
    end
  end

  // R6 tracking: request stalled on the previous edge
  bit stall_p; logic [7:0] stall_d; logic stall_n;
  always @(posedge clk_i) begin
    stall_p <= rst_ni && req_o && !rdy_i;
    stall_d <= data_o;
    stall_n <= nibble_o;
  end

  always @(negedge clk_i) begin
    cyc++;
    case (mode)
      1: begin lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; rdy_i = lfsr[0]; end
      2: rdy_i = ((cyc % 9) >= 6);
      default: rdy_i = 1'b1;
    endcase
    #1;
    if (rst_ni) begin
      chk(req_o === e_req, ctx, req_o, e_req);
      chk(done_o === e_done, "R7", done_o, e_done);
      chk(rs_o === 1'b0, "R5", rs_o, 0);
      if (e_req && req_o) begin
        chk(data_o === qd[0][7:0], (qn[0] != 0) ? "R2" : "R4", data_o, qd[0]);
        chk(nibble_o === qn[0][0], (qn[0] != 0) ? "R2" : "R4", nibble_o, qn[0]);
      end
      if (stall_p) chk(req_o && data_o === stall_d && nibble_o === stall_n, "R6", data_o, stall_d);
    end
  end

  task automatic pulse_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    chk(req_o === 1'b0, "R1", req_o, 0);
    chk(done_o === 1'b0, "R1", done_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run_to_done(input int limit);
    int k;
    for (k = 0; k < limit && !done_o; k++) @(negedge clk_i);
    #2;
    chk(done_o === 1'b1, "R7", done_o, 1);
    repeat (12) @(negedge clk_i);
    #2;
    chk(done_o === 1'b1 && req_o === 1'b0, "R7", done_o, 1);
    chk(n_acc == 8, "R9", n_acc, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #2;
    chk(req_o === 1'b0 && done_o === 1'b0, "R1", req_o, 0);
    rst_ni = 1'b1;
    run_to_done(2000);

    mode = 1;
    pulse_reset();
    repeat (60) @(negedge clk_i);
    mid_tag = "R8";
    pulse_reset();
    run_to_done(4000);

    mode = 2;
    mid_tag = "R1";
    pulse_reset();
    repeat (PWR + 8) @(negedge clk_i);
    mid_tag = "R8";
    pulse_reset();
    run_to_done(4000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule